// File: doc/BRIEF.md
# Shared Prescaler with Synchronized Timer Release

This block is the clock prescaler that two timer/counters share. It has a free-running counter that produces single-cycle tick strobes at several divide ratios. Each timer picks its own ratio with a 3-bit select input. A small 8-bit control register holds a synchronization-mode bit and two prescaler-reset bits. Software reads and writes this register through a plain write-strobe/read-data port.

Normally a prescaler-reset bit clears itself one clock after software sets it, so it gives a short restart of the divider. While synchronization mode is on, the reset bits stay as written. A set synchronous-reset bit then holds the divider at zero, suppresses all strobes and raises a halt output, so software can load both timers without either one advancing. Clearing synchronization mode drops both reset bits in the same cycle. Both timers then restart from a common divider phase. The asynchronous-reset bit is only stored and read back, because that prescaler is outside this block.

Top module: `presc_sync_ctrl`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), rd_data reads 0x00 and halt, tick_a and tick_b are 0.
- R2: rd_data bit 7 is the sync-mode bit, bit 1 the asynchronous-reset flag and bit 0 the synchronous-reset flag. Bits 6 to 2 always read 0, whatever is written.
- R3: A write taken while sync mode is 0 stores bits 1:0. Any reset flag that is 1 reads back 1 for exactly one cycle, and the hardware then clears it.
- R4: While sync mode is 1, the reset flags keep the written value. If a single write sets bit 7 and a reset bit together, that reset bit is held from that write onward.
- R5: A write with bit 7 = 0 taken while sync mode is 1 clears sync mode and both reset flags at the next edge, whatever bits 1:0 are.
- R6: halt equals the synchronous-reset flag. Every edge at which it is 1 loads the divider with zero, and the next cycle carries no tick on either channel.
- R7: Select encoding per channel: 0 = stopped, 1 = divide by 1, 2 = by 8, 3 = by 64, 4 = by 256, 5 = by 1024, 6 and 7 = stopped. For a ratio above 1, each strobe lasts one cycle.
- R8: After halt falls, the first divide-by-N strobe appears N cycles later, and then every N cycles. Both channels share this phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| sel_a | input | 3 | Divide select, timer A |
| sel_b | input | 3 | Divide select, timer B |
| tick_a | output | 1 | Prescaled strobe, timer A |
| tick_b | output | 1 | Prescaled strobe, timer B |
| halt | output | 1 | High while the shared prescaler is held in reset |

## Verification
On every cycle, the in-line properties check the flag rules: self-clear outside sync mode, holding inside it, and the release clearing both flags. They also check that a halted divider sits at zero with no strobes, that a stopped select gives nothing, and that strobes above divide-by-1 last one cycle. Only the bench's scenarios can show the exact delay from halt falling to the first strobe for each ratio and the phase shared by the two channels, including the divide-by-1024 wrap. A per-cycle reference model, compared after every edge, covers these.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int SEL_W  = 3;
  localparam int SHFT_W = 5;

  // log2 of the divide ratio chosen by a select code
  function automatic logic [SHFT_W-1:0] div_shift(input logic [SEL_W-1:0] s);
    case (s)
      3'd1:    div_shift = 5'd0;
      3'd2:    div_shift = 5'd3;
      3'd3:    div_shift = 5'd6;
      3'd4:    div_shift = 5'd8;
      3'd5:    div_shift = 5'd10;
      default: div_shift = 5'd0;
    endcase
  endfunction

  function automatic logic div_active(input logic [SEL_W-1:0] s);
    div_active = (s >= 3'd1) && (s <= 3'd5);
  endfunction
endpackage

// File: rtl/presc_ctrl_reg.sv
module presc_ctrl_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             sync_mode,
  output logic             flag_async,
  output logic             flag_sync
);
  localparam int MODE_BIT = REG_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_mode  <= 1'b0;
      flag_async <= 1'b0;
      flag_sync  <= 1'b0;
    end else if (wr_en) begin
      if (sync_mode && !wr_data[MODE_BIT]) begin
        // leaving sync mode releases both prescaler resets together
        sync_mode  <= 1'b0;
        flag_async <= 1'b0;
        flag_sync  <= 1'b0;
      end else begin
        sync_mode  <= wr_data[MODE_BIT];
        flag_async <= wr_data[1];
        flag_sync  <= wr_data[0];
      end
    end else if (!sync_mode) begin
      flag_async <= 1'b0;
      flag_sync  <= 1'b0;
    end
  end

  p_selfclear_r3: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && !wr_en && (flag_sync || flag_async)) |=> (!flag_sync && !flag_async));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !wr_en) |=> ($stable(flag_sync) && $stable(flag_async) && sync_mode));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && wr_en && !wr_data[MODE_BIT]) |=> (!sync_mode && !flag_sync && !flag_async));
endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else             cnt <= cnt + ONE;
  end

  p_held_zero_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));
endmodule

// File: rtl/presc_tick.sv
module presc_tick
  import presc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] cnt,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    mask = ~({CNT_W{1'b1}} << div_shift(sel));
    nxt  = cnt + ONE;
  end

  // strobe when the count about to be reached is a multiple of the ratio
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= !hold && div_active(sel) && ((nxt & mask) == '0);
  end

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tick);

  p_stopped_r7: assert property (@(posedge clk) disable iff (rst)
    !div_active(sel) |=> !tick);

  p_single_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && $stable(sel) && (sel >= 3'd2) && (sel <= 3'd5)) |=> !tick);
endmodule

// File: rtl/presc_sync_ctrl.sv
module presc_sync_ctrl
  import presc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic             tick_a,
  output logic             tick_b,
  output logic             halt
);
  localparam int N_CH = 2;

  logic             sync_mode, flag_async, flag_sync;
  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_v  [N_CH];
  logic [N_CH-1:0]  tick_v;

  presc_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sync_mode(sync_mode), .flag_async(flag_async), .flag_sync(flag_sync)
  );

  presc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(flag_sync), .cnt(cnt)
  );

  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    presc_tick #(.CNT_W(CNT_W)) u_tick (
      .clk(clk), .rst(rst), .hold(flag_sync), .sel(sel_v[g]),
      .cnt(cnt), .tick(tick_v[g])
    );
  end

  assign tick_a  = tick_v[0];
  assign tick_b  = tick_v[1];
  assign halt    = flag_sync;
  assign rd_data = {sync_mode, {(REG_W-3){1'b0}}, flag_async, flag_sync};
endmodule

// File: tb/presc_sync_ctrl_tb.sv
`timescale 1ns/1ps
module presc_sync_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] sel_a = 3'd0, sel_b = 3'd0;
  logic [7:0] rd_data;
  logic       tick_a, tick_b, halt;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  // reference state
  bit m_mode, m_fa, m_fs, m_ta, m_tb;
  int m_cnt;

  always #2 clk = ~clk;

  presc_sync_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sel_a(sel_a), .sel_b(sel_b), .tick_a(tick_a), .tick_b(tick_b), .halt(halt)
  );

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit n_mode, n_fa, n_fs, n_ta, n_tb;
    int n_cnt, ra, rb;
    if (rst) begin
      n_mode = 0; n_fa = 0; n_fs = 0; n_ta = 0; n_tb = 0; n_cnt = 0;
    end else begin
      ra = ratio(sel_a); rb = ratio(sel_b);
      n_ta = !m_fs && ra > 0 && (((m_cnt + 1) % ra) == 0);
      n_tb = !m_fs && rb > 0 && (((m_cnt + 1) % rb) == 0);
      n_cnt = m_fs ? 0 : (m_cnt + 1) % 1024;
      n_mode = m_mode; n_fa = m_fa; n_fs = m_fs;
      if (wr_en) begin
        if (m_mode && !wr_data[7]) begin
          n_mode = 0; n_fa = 0; n_fs = 0;
        end else begin
          n_mode = wr_data[7]; n_fa = wr_data[1]; n_fs = wr_data[0];
        end
      end else if (!m_mode) begin
        n_fa = 0; n_fs = 0;
      end
    end
    m_mode = n_mode; m_fa = n_fa; m_fs = n_fs; m_ta = n_ta; m_tb = n_tb; m_cnt = n_cnt;
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rd_data", rd_data, {m_mode, 5'b0, m_fa, m_fs});
    check("halt",    {7'b0, halt},   {7'b0, m_fs});
    check("tick_a",  {7'b0, tick_a}, {7'b0, m_ta});
    check("tick_b",  {7'b0, tick_b}, {7'b0, m_tb});
  endtask

  task automatic step(input logic we, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    wr_en = we; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    phase = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);

    // R7: select encodings, stopped codes included
    phase = "R7";
    sel_a = 3'd1; sel_b = 3'd2; idle(40);
    sel_a = 3'd3; sel_b = 3'd4; idle(600);
    sel_a = 3'd5; sel_b = 3'd0; idle(2100);
    sel_a = 3'd6; sel_b = 3'd7; idle(30);

    // R3: self-clearing reset flags outside sync mode
    phase = "R3";
    sel_a = 3'd2; sel_b = 3'd1;
    step(1'b1, 8'h01); idle(20);
    step(1'b1, 8'h02); idle(5);
    step(1'b1, 8'h03); idle(20);

    // R4 + R6: sync mode holds the resets, prescaler halted
    phase = "R4";
    step(1'b1, 8'h80); idle(10);
    step(1'b1, 8'h81); idle(30);
    step(1'b1, 8'h82); idle(5);
    step(1'b1, 8'h83); idle(5);
    phase = "R6";
    idle(20);

    // R5 + R8: release, then aligned restart
    phase = "R5";
    sel_a = 3'd5; sel_b = 3'd4;
    step(1'b1, 8'h03); idle(3);
    phase = "R8";
    idle(1100);
    sel_a = 3'd2; sel_b = 3'd3;
    phase = "R4";
    step(1'b1, 8'h81); idle(12);
    phase = "R8";
    step(1'b1, 8'h00); idle(140);

    // R2: reserved bits read zero; release with stray data
    phase = "R2";
    step(1'b1, 8'hFF); idle(4);
    step(1'b1, 8'h7F); idle(4);
    step(1'b1, 8'h7C); idle(4);

    // R1: reset again mid-activity
    phase = "R1";
    step(1'b1, 8'h83);
    rst = 1'b1; idle(3);
    rst = 1'b0; idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule